// File: doc/BRIEF.md
# Inbound Address Window Translator

This block turns the 34-bit address carried by an inbound request into a 32-bit address for the local memory-mapped bus. The translation comes from a small bank of programmable windows. Each window holds a base, a mask and an offset for the low 32 address bits. It also holds two extended compare bits covering request address bits 33:32, each with its own mask bit, and an enable. Software sets up the windows through a narrow write/read register port. Requests are presented on a lookup port. One cycle later the block returns the translated address, a hit flag and the number of the window that was used. On a miss it returns an error flag instead, which the caller turns into an error response.

All enabled windows are compared in parallel. When several match, the one with the lowest index wins. Address bits under the window mask come from the offset, and bits outside the mask pass through from the request. Bit 2 of the result depends on the datapath width and the access size.

Top module: `xlat_window_match`

## Requirements
- R1: After reset the result outputs `res_valid`, `res_hit` and `res_err` are low, and every field of every window reads back as zero, so every window is disabled.
- R2: Register field select `cfg_fld` works as follows. Value 0 selects the base, 1 the mask and 2 the offset; each of these keeps bits 31:3, and its bits 2:0 read as zero whatever is written. Value 3 selects control: bit 0 is the enable, bits 2:1 are the extended mask and bits 4:3 are the extended base. Bits 31:5 of control read as zero. A write takes effect at the clock edge where `cfg_wr` is high.
- R3: A window whose enable is clear never matches, whatever its other fields hold.
- R4: An enabled window matches when `(lk_addr & {xmask, mask}) == ({xbase, base} & {xmask, mask})`. In this compare, the extended fields cover address bits 33:32 and mask and base cover bits 31:0.
- R5: When several enabled windows match, the lowest-numbered one is used, and its number appears on `res_win`.
- R6: On a hit, `res_addr[31:3] = (offset[31:3] & mask[31:3]) | (lk_addr[31:3] & ~mask[31:3])` of the selected window.
- R7: `res_addr[1:0]` is always zero. When `lk_dp32` is 0 (64-bit datapath), `res_addr[2]` is zero.
- R8: When `lk_dp32` is 1 (32-bit datapath), `res_addr[2]` equals `lk_wdptr` if `lk_size` (bytes in the access) is 4 or less. It is zero if `lk_size` is 5 or more.
- R9: A lookup that matches no enabled window raises `res_err` with `res_hit` low, `res_win` zero and `res_addr` zero.
- R10: Results are registered. `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. `res_hit` and `res_err` are never high together, and both are low whenever `res_valid` is low.
- R11: A lookup in the same cycle as a register write is judged against the window settings from before that write. The write applies to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | Window number for write and read |
| cfg_fld | input | 2 | Field select: 0 base, 1 mask, 2 offset, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected field (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 34 | Inbound request address |
| lk_dp32 | input | 1 | 1: 32-bit datapath, 0: 64-bit datapath |
| lk_wdptr | input | 1 | Word pointer of the request |
| lk_size | input | 4 | Access size in bytes |
| res_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| res_hit | output | 1 | Lookup matched an enabled window |
| res_err | output | 1 | Lookup matched no enabled window |
| res_win | output | SEL_W | Number of the window used |
| res_addr | output | 32 | Translated local address |

## Verification
Two functions can fall in the same cycle. The first is priority resolution: two windows can claim the same address. The bench provokes this with overlapping windows, including one whose extended mask ignores bit 33. It checks that the lower index wins, then disables that window to confirm the other one takes over. The second is a register write that lands in the same cycle as a lookup. The bench issues both in one cycle and expects the old settings, which give a miss. It then expects a hit from the very next lookup. The sweep computes every expected result from a model of the window registers kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int REQ_AW = 34;
   localparam int LOC_AW = 32;
   localparam int EXT_W  = REQ_AW - LOC_AW;
   localparam int GRAN_W = 3;

   typedef enum logic [1:0] {
      FLD_BASE = 2'd0,
      FLD_MASK = 2'd1,
      FLD_OFFS = 2'd2,
      FLD_CTRL = 2'd3
   } fld_e;

   typedef struct packed {
      logic                     en;
      logic [EXT_W-1:0]         xbase;
      logic [EXT_W-1:0]         xmask;
      logic [LOC_AW-1:GRAN_W]   base;
      logic [LOC_AW-1:GRAN_W]   mask;
      logic [LOC_AW-1:GRAN_W]   offs;
   } win_t;

endpackage

// File: rtl/xlat_win_bank.sv
module xlat_win_bank
   import xlat_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int SEL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [1:0]        cfg_fld,
   input  logic [LOC_AW-1:0] cfg_wdata,
   output logic [LOC_AW-1:0] cfg_rdata,
   output win_t              win_q [NUM_WIN]
);

   logic sel_ok;
   assign sel_ok = (32'(cfg_sel) < NUM_WIN);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      win_t cur_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur_q <= '0;
         end else if (cfg_wr && cfg_sel == SEL_W'(w)) begin
            case (fld_e'(cfg_fld))
               FLD_BASE: cur_q.base <= cfg_wdata[LOC_AW-1:GRAN_W];
               FLD_MASK: cur_q.mask <= cfg_wdata[LOC_AW-1:GRAN_W];
               FLD_OFFS: cur_q.offs <= cfg_wdata[LOC_AW-1:GRAN_W];
               FLD_CTRL: begin
                  cur_q.en    <= cfg_wdata[0];
                  cur_q.xmask <= cfg_wdata[EXT_W:1];
                  cur_q.xbase <= cfg_wdata[2*EXT_W:EXT_W+1];
               end
            endcase
         end
      end
      assign win_q[w] = cur_q;
   end

   always_comb begin
      cfg_rdata = '0;
      if (sel_ok) begin
         case (fld_e'(cfg_fld))
            FLD_BASE: cfg_rdata = {win_q[cfg_sel].base, GRAN_W'(0)};
            FLD_MASK: cfg_rdata = {win_q[cfg_sel].mask, GRAN_W'(0)};
            FLD_OFFS: cfg_rdata = {win_q[cfg_sel].offs, GRAN_W'(0)};
            FLD_CTRL: cfg_rdata = LOC_AW'({win_q[cfg_sel].xbase,
                                           win_q[cfg_sel].xmask,
                                           win_q[cfg_sel].en});
         endcase
      end
   end

endmodule

// File: rtl/xlat_win_cmp.sv
module xlat_win_cmp
   import xlat_pkg::*;
(
   input  win_t              win,
   input  logic [REQ_AW-1:0] addr,
   output logic              hit
);

   logic [REQ_AW-1:0] cmp_mask;
   logic [REQ_AW-1:0] cmp_base;

   assign cmp_mask = {win.xmask, win.mask, GRAN_W'(0)};
   assign cmp_base = {win.xbase, win.base, GRAN_W'(0)};
   assign hit      = win.en && ((addr & cmp_mask) == (cmp_base & cmp_mask));

endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick #(
   parameter int NUM_WIN = 4,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_WIN-1:0] req,
   output logic               any,
   output logic [SEL_W-1:0]   idx
);

   assign any = |req;

   if (NUM_WIN == 1) begin : g_single
      assign idx = '0;
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) idx = SEL_W'(i);
         end
      end
   end

endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
   import xlat_pkg::*;
#(
   parameter  int NUM_WIN = 4,
   localparam int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [1:0]        cfg_fld,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              lk_valid,
   input  logic [33:0]       lk_addr,
   input  logic              lk_dp32,
   input  logic              lk_wdptr,
   input  logic [3:0]        lk_size,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_err,
   output logic [SEL_W-1:0]  res_win,
   output logic [31:0]       res_addr
);

   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_num_win
      $error("xlat_window_match: NUM_WIN must lie in 1..16");
   end

   win_t               win_q [NUM_WIN];
   logic [NUM_WIN-1:0] hit_vec;
   logic               any_hit;
   logic [SEL_W-1:0]   pick;
   logic [LOC_AW-1:GRAN_W] sel_mask;
   logic [LOC_AW-1:GRAN_W] sel_offs;
   logic               word_hi;
   logic [LOC_AW-1:0]  xl_addr;
   logic               take;

   xlat_win_bank #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_fld   (cfg_fld),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .win_q     (win_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      xlat_win_cmp u_cmp (
         .win  (win_q[w]),
         .addr (lk_addr),
         .hit  (hit_vec[w])
      );

      // R3: a disabled window must not report a match
      a_r3_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
         !win_q[w].en |-> !hit_vec[w]);
   end

   xlat_prio_pick #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_pick (
      .req (hit_vec),
      .any (any_hit),
      .idx (pick)
   );

   logic [NUM_WIN-1:0] below_pick;
   assign below_pick = (NUM_WIN'(1) << pick) - NUM_WIN'(1);

   // R5: chosen window really matched, and no lower one did
   a_r5_pick_matches: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> hit_vec[pick]);
   a_r5_no_lower_hit: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> ((hit_vec & below_pick) == '0));

   assign sel_mask = win_q[pick].mask;
   assign sel_offs = win_q[pick].offs;
   assign word_hi  = lk_dp32 && (lk_size <= 4'd4) && lk_wdptr;
   assign xl_addr  = {(sel_offs & sel_mask) | (lk_addr[LOC_AW-1:GRAN_W] & ~sel_mask),
                      word_hi, 2'b00};
   assign take     = lk_valid && any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_err   <= 1'b0;
         res_win   <= '0;
         res_addr  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_hit   <= take;
         res_err   <= lk_valid && !any_hit;
         res_win   <= take ? pick : '0;
         res_addr  <= take ? xl_addr : '0;
      end
   end

   // R10: result timing and flag exclusivity
   a_r10_hit_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_hit && res_err));
   a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   a_r10_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!res_valid && !res_hit && !res_err));

   // R9: a miss carries no address and no window number
   a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_addr == '0 && res_win == '0));

endmodule

// File: tb/xlat_window_match_test.sv
module xlat_window_match_test;

   localparam int NW = 4;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_wr;
   logic [SW-1:0] cfg_sel;
   logic [1:0]    cfg_fld;
   logic [31:0]   cfg_wdata;
   logic [31:0]   cfg_rdata;
   logic          lk_valid;
   logic [33:0]   lk_addr;
   logic          lk_dp32;
   logic          lk_wdptr;
   logic [3:0]    lk_size;
   logic          res_valid;
   logic          res_hit;
   logic          res_err;
   logic [SW-1:0] res_win;
   logic [31:0]   res_addr;

   always #5 clk = ~clk;

   xlat_window_match #(.NUM_WIN(NW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_dp32(lk_dp32),
      .lk_wdptr(lk_wdptr), .lk_size(lk_size), .res_valid(res_valid),
      .res_hit(res_hit), .res_err(res_err), .res_win(res_win),
      .res_addr(res_addr)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] mb  [NW];
   logic [31:0] mm  [NW];
   logic [31:0] mo  [NW];
   logic [1:0]  mxb [NW];
   logic [1:0]  mxm [NW];
   logic        men [NW];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int w, input logic [1:0] f, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = SW'(w); cfg_fld = f; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_wr = 1'b0;
      case (f)
         2'd0: mb[w] = d & ~32'h7;
         2'd1: mm[w] = d & ~32'h7;
         2'd2: mo[w] = d & ~32'h7;
         default: begin men[w] = d[0]; mxm[w] = d[2:1]; mxb[w] = d[4:3]; end
      endcase
   endtask

   task automatic rd_chk(input string tag, input int w, input logic [1:0] f, input logic [31:0] exp);
      cfg_sel = SW'(w); cfg_fld = f;
      #1 chk(tag, cfg_rdata, exp);
   endtask

   function automatic void model(input logic [33:0] a, input bit dp32, input bit wp,
                                 input logic [3:0] sz, output bit hit, output int idx,
                                 output logic [31:0] xa);
      hit = 1'b0; idx = 0; xa = '0;
      for (int w = 0; w < NW; w++) begin
         logic [33:0] m;
         logic [33:0] b;
         m = {mxm[w], mm[w]};
         b = {mxb[w], mb[w]};
         if (!hit && men[w] && ((a & m) == (b & m))) begin
            hit = 1'b1;
            idx = w;
            xa = ((mo[w] & mm[w]) | (a[31:0] & ~mm[w])) & ~32'h7;
            if (dp32 && sz <= 4'd4 && wp) xa[2] = 1'b1;
         end
      end
   endfunction

   task automatic look(input logic [33:0] a, input bit dp32, input bit wp, input logic [3:0] sz);
      bit eh; int ei; logic [31:0] ea;
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a; lk_dp32 = dp32; lk_wdptr = wp; lk_size = sz;
      model(a, dp32, wp, sz, eh, ei, ea);
      @(posedge clk);
      #1 lk_valid = 1'b0;
      chk("R10 res_valid", res_valid, 1);
      chk("R4 res_hit", res_hit, eh);
      chk("R9 res_err", res_err, !eh);
      chk("R5 res_win", res_win, eh ? SW'(ei) : '0);
      chk("R6 res_addr[31:3]", res_addr[31:3], ea[31:3]);
      if (dp32) chk("R8 res_addr[2]", res_addr[2], ea[2]);
      else      chk("R7 res_addr[2]", res_addr[2], 1'b0);
      chk("R7 res_addr[1:0]", res_addr[1:0], 2'b00);
   endtask

   task automatic idle_chk;
      @(posedge clk);
      #1;
      chk("R10 idle res_valid", res_valid, 0);
      chk("R10 idle res_hit", res_hit, 0);
      chk("R10 idle res_err", res_err, 0);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R10 watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [27:0] pat [4];
      pat[0] = 28'h0000000; pat[1] = 28'h2345678;
      pat[2] = 28'hABCDEF4; pat[3] = 28'hFFFFFFF;
      for (int w = 0; w < NW; w++) begin
         mb[w] = '0; mm[w] = '0; mo[w] = '0; mxb[w] = '0; mxm[w] = '0; men[w] = 1'b0;
      end
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_fld = '0; cfg_wdata = '0;
      lk_valid = 1'b0; lk_addr = '0; lk_dp32 = 1'b0; lk_wdptr = 1'b0; lk_size = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 res_valid", res_valid, 0);
      chk("R1 res_hit", res_hit, 0);
      chk("R1 res_err", res_err, 0);
      for (int w = 0; w < NW; w++)
         for (int f = 0; f < 4; f++) rd_chk("R1 readback", w, 2'(f), 32'h0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R1: with all windows disabled any lookup misses
      look(34'h1_2345_6780, 1'b0, 1'b0, 4'd8);

      // R2: field widths and zero low bits
      wr(0, 2'd0, 32'hFFFF_FFFF); rd_chk("R2 base", 0, 2'd0, 32'hFFFF_FFF8);
      wr(0, 2'd1, 32'hFFFF_FFFF); rd_chk("R2 mask", 0, 2'd1, 32'hFFFF_FFF8);
      wr(0, 2'd2, 32'hFFFF_FFFF); rd_chk("R2 offset", 0, 2'd2, 32'hFFFF_FFF8);
      wr(0, 2'd3, 32'hFFFF_FFFF); rd_chk("R2 control", 0, 2'd3, 32'h0000_001F);
      rd_chk("R2 other window untouched", 1, 2'd0, 32'h0);

      // window setup: w0 and w1 overlap, w2 catches extended region 2, w3 disabled
      wr(0, 2'd0, 32'h1000_0000); wr(0, 2'd1, 32'hF000_0000);
      wr(0, 2'd2, 32'h8000_0000); wr(0, 2'd3, 32'h0000_0007);
      wr(1, 2'd0, 32'h1200_0000); wr(1, 2'd1, 32'hFF00_0000);
      wr(1, 2'd2, 32'h4400_0000); wr(1, 2'd3, 32'h0000_0003);
      wr(2, 2'd0, 32'h0000_0000); wr(2, 2'd1, 32'h0000_0000);
      wr(2, 2'd2, 32'h0000_0000); wr(2, 2'd3, 32'h0000_0017);
      wr(3, 2'd0, 32'h2000_0000); wr(3, 2'd1, 32'hF000_0000);
      wr(3, 2'd2, 32'hC000_0000); wr(3, 2'd3, 32'h0000_0006);

      // R4 R5 R6 R7 R8 R9: sweep of extended bits, top nibble, patterns and modes
      for (int x = 0; x < 4; x++)
         for (int n = 0; n < 16; n++)
            for (int k = 0; k < 4; k++)
               look({2'(x), 4'(n), pat[k]}, k[0], k[1] ^ n[0], 4'(n % 9));
      idle_chk();

      // R5: overlap 0x12... resolved to w0, then w1 once w0 is off
      look(34'h0_1234_5678, 1'b0, 1'b0, 4'd8);
      chk("R5 overlap picks w0", res_win, 2'd0);
      look(34'h2_1234_5678, 1'b1, 1'b1, 4'd2);
      chk("R5 bit33 ignored by w1", res_win, 2'd1);
      wr(0, 2'd3, 32'h0000_0006);
      look(34'h0_1234_5678, 1'b0, 1'b0, 4'd8);
      chk("R5 w1 after w0 off", res_win, 2'd1);

      // R3: disabled w3 with matching fields misses
      look(34'h0_2000_0040, 1'b1, 1'b1, 4'd4);
      chk("R3 disabled window miss", res_err, 1);

      // R11: write and lookup in the same cycle use the old settings
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_fld = 2'd3; cfg_wdata = 32'h0000_0007;
      lk_valid = 1'b1; lk_addr = 34'h0_2000_0040; lk_dp32 = 1'b0; lk_size = 4'd8;
      @(posedge clk);
      #1 cfg_wr = 1'b0; lk_valid = 1'b0;
      chk("R11 same-cycle lookup uses old settings", res_err, 1);
      chk("R11 same-cycle lookup no hit", res_hit, 0);
      men[3] = 1'b1; mxm[3] = 2'd3; mxb[3] = 2'd0;
      look(34'h0_2000_0040, 1'b0, 1'b0, 4'd8);
      chk("R11 next lookup sees write", res_hit, 1);
      chk("R11 next lookup address", res_addr, 32'hC000_0040);

      // R8: size boundary 4 vs 5 in 32-bit mode
      look(34'h0_2000_0040, 1'b1, 1'b1, 4'd4);
      chk("R8 size 4 takes wdptr", res_addr[2], 1'b1);
      look(34'h0_2000_0040, 1'b1, 1'b1, 4'd5);
      chk("R8 size 5 gives zero", res_addr[2], 1'b0);
      look(34'h3_2000_0040, 1'b0, 1'b0, 4'd8);
      chk("R9 extended mismatch miss", res_err, 1);
      idle_chk();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule